// File: doc/BRIEF.md
# Digital One-Shot and Free-Running Pulse Timer

This block is a clock-driven model of a comparator-and-latch timer. It has two modes. In one-shot mode an active-low trigger level starts an output pulse whose length comes from a programmable count. In free-running mode the block retriggers itself and produces a pulse train. The high phase and the low phase of that train each have their own count. Counters stand in for the capacitor charge and discharge, so all timing is in whole clock cycles.

The block drives two outputs. `tmr_out` is the timer output. `discharge` is high whenever the timer is not in its high phase. An active-low clear input, `clr_n`, is a level input that takes priority over every other input. The asynchronous `rst_n` initialises the flops; its release is synchronised inside the block.

Top module: `pulse_timer`

## Requirements
- R1: With `mode`=0 (one-shot), `clr_n` high and `tmr_out` low, `trig_n` sampled low at a clock edge sets `tmr_out` high and `discharge` low from that edge on. The pulse then lasts `high_count` cycles.
- R2: `clr_n` sampled low at an edge forces `tmr_out` low and `discharge` high after that edge. No trigger can start a pulse while `clr_n` stays low.
- R3: While `rst_n` is held low, and in the idle state, `tmr_out` is 0 and `discharge` is 1. At all times `discharge` is the complement of `tmr_out`.
- R4: In one-shot mode, a trigger pulse that arrives during the high phase and is released before the phase ends leaves the pulse length unchanged.
- R5: In one-shot mode, if `trig_n` is still low in the last cycle of the high phase, a new interval starts at once and `tmr_out` stays high without a gap.
- R6: With `mode`=1 (free-running), `tmr_out` alternates between a high phase of `high_count` cycles and a low phase of `low_count` cycles. `trig_n` has no effect in this mode.
- R7: A count input of zero gives a phase of one cycle.
- R8: Each count input is sampled when its phase begins. A change during a phase affects only later phases.
- R9: After `clr_n` is released, the timer is idle with `tmr_out` low in one-shot mode. In free-running mode it enters the high phase at the first edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 1 | 0 = one-shot, 1 = free-running |
| trig_n | input | 1 | Active-low trigger level |
| clr_n | input | 1 | Active-low clear level, takes priority over all other inputs |
| high_count | input | CNT_W | High phase length in cycles (0 counts as 1) |
| low_count | input | CNT_W | Low phase length in cycles (0 counts as 1) |
| tmr_out | output | 1 | Timer output |
| discharge | output | 1 | High whenever the timer is not in its high phase |

## Verification
The bench targets four corner cases:
- Zero counts. A design that loaded zero directly would wrap its down-counter and hold the output for a full counter range.
- A trigger held low across several interval ends. An edge-sensitive or gap-producing design would drop `tmr_out` for a cycle, or end the pulse early.
- A count changed in the middle of a phase. A design that compared against the live input instead of a loaded value would cut that phase short.
- A clear applied during a pulse, with the trigger held low. A design that gave the trigger priority would keep `tmr_out` high.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

  typedef enum logic [1:0] {
    PT_IDLE = 2'd0,
    PT_HIGH = 2'd1,
    PT_LOW  = 2'd2
  } pt_state_e;

  typedef enum logic {
    PT_SEL_HIGH = 1'b0,
    PT_SEL_LOW  = 1'b1
  } pt_len_sel_e;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/pt_len_clamp.sv
module pt_len_clamp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] len_in,
  output logic [CNT_W-1:0] len_out
);

  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(1);

  always_comb begin
    if (len_in == '0) begin
      len_out = MIN_LEN;
    end else begin
      len_out = len_in;
    end
  end

endmodule

// File: rtl/pt_phase_cnt.sv
module pt_phase_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == ONE);

endmodule

// File: rtl/pt_fsm.sv
module pt_fsm
  import pulse_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_sn,
  input  logic        clr_n,
  input  logic        mode,
  input  logic        trig_n,
  input  logic        phase_last,
  output pt_state_e   state,
  output logic        load,
  output pt_len_sel_e load_sel,
  output logic        dec
);

  pt_state_e state_q;
  pt_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_sel = PT_SEL_HIGH;
    if (!clr_n) begin
      state_d = PT_IDLE;
    end else begin
      unique case (state_q)
        PT_IDLE: begin
          if (mode || !trig_n) begin
            state_d = PT_HIGH;
            load    = 1'b1;
          end
        end
        PT_HIGH: begin
          if (phase_last) begin
            if (mode) begin
              state_d  = PT_LOW;
              load     = 1'b1;
              load_sel = PT_SEL_LOW;
            end else if (!trig_n) begin
              state_d = PT_HIGH;
              load    = 1'b1;
            end else begin
              state_d = PT_IDLE;
            end
          end
        end
        PT_LOW: begin
          if (!mode) begin
            if (!trig_n) begin
              state_d = PT_HIGH;
              load    = 1'b1;
            end else begin
              state_d = PT_IDLE;
            end
          end else if (phase_last) begin
            state_d = PT_HIGH;
            load    = 1'b1;
          end
        end
        default: state_d = PT_IDLE;
      endcase
    end
    dec = clr_n && (state_q != PT_IDLE) && !load;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= PT_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             trig_n,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] high_count,
  input  logic [CNT_W-1:0] low_count,
  output logic             tmr_out,
  output logic             discharge
);

  logic             rst_sn;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] phase_cnt;
  logic             phase_last;
  logic             load;
  logic             dec;
  pt_len_sel_e      load_sel;
  pt_state_e        state;

  pt_rst_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pt_len_clamp #(.CNT_W(CNT_W)) u_clamp_high (
    .len_in  (high_count),
    .len_out (high_len)
  );

  pt_len_clamp #(.CNT_W(CNT_W)) u_clamp_low (
    .len_in  (low_count),
    .len_out (low_len)
  );

  assign load_val = (load_sel == PT_SEL_LOW) ? low_len : high_len;

  pt_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .load     (load),
    .dec      (dec),
    .load_val (load_val),
    .cnt      (phase_cnt),
    .last     (phase_last)
  );

  pt_fsm u_fsm (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .clr_n      (clr_n),
    .mode       (mode),
    .trig_n     (trig_n),
    .phase_last (phase_last),
    .state      (state),
    .load       (load),
    .load_sel   (load_sel),
    .dec        (dec)
  );

  assign tmr_out   = (state == PT_HIGH);
  assign discharge = ~tmr_out;

endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic             trig_n,
  input logic             clr_n,
  input logic             tmr_out,
  input logic             discharge,
  input logic [CNT_W-1:0] cnt
);

  AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!tmr_out && discharge)); // R2

  AST_ONESHOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !mode && !trig_n && !tmr_out) |=> tmr_out); // R1

  AST_HELD_TRIG_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !mode && !trig_n && tmr_out) |=> tmr_out); // R5

  AST_CLR_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> (!tmr_out && discharge)); // R9

  AST_HIGH_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_out |-> (cnt != '0)); // R7

endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .trig_n    (trig_n),
  .clr_n     (clr_n),
  .tmr_out   (tmr_out),
  .discharge (discharge),
  .cnt       (phase_cnt)
);

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NV         = 8;
  localparam int WD_CYCLES  = 150000;

  // {mode, high_count, low_count, exp_high, exp_low}, 8 bits each
  localparam logic [39:0] VEC [NV] = '{
    {8'd0, 8'd5,  8'd0, 8'd5,  8'd0},
    {8'd0, 8'd1,  8'd0, 8'd1,  8'd0},
    {8'd0, 8'd0,  8'd0, 8'd1,  8'd0},
    {8'd0, 8'd12, 8'd0, 8'd12, 8'd0},
    {8'd1, 8'd3,  8'd7, 8'd3,  8'd7},
    {8'd1, 8'd6,  8'd2, 8'd6,  8'd2},
    {8'd1, 8'd0,  8'd0, 8'd1,  8'd1},
    {8'd1, 8'd1,  8'd4, 8'd1,  8'd4}
  };

  logic             clk;
  logic             rst_n;
  logic             mode;
  logic             trig_n;
  logic             clr_n;
  logic [CNT_W-1:0] high_count;
  logic [CNT_W-1:0] low_count;
  logic             tmr_out;
  logic             discharge;

  int n_chk;
  int n_fail;

  pulse_timer #(.CNT_W(CNT_W)) u_pulse_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .trig_n     (trig_n),
    .clr_n      (clr_n),
    .high_count (high_count),
    .low_count  (low_count),
    .tmr_out    (tmr_out),
    .discharge  (discharge)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic count_level(input logic lvl, output int len);
    len = 0;
    while (tmr_out == lvl && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic wait_level(input logic lvl);
    int guard;
    guard = 0;
    while (tmr_out != lvl && guard < 1000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic m, input int hi, input int lo);
    @(negedge clk);
    clr_n      = 1'b0;
    trig_n     = 1'b1;
    mode       = m;
    high_count = CNT_W'(hi);
    low_count  = CNT_W'(lo);
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len;
    int len2;
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    mode       = 1'b0;
    trig_n     = 1'b1;
    clr_n      = 1'b1;
    high_count = '0;
    low_count  = '0;
    repeat (3) @(negedge clk);
    check("R3 reset out", int'(tmr_out), 0);
    check("R3 reset discharge", int'(discharge), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 idle out", int'(tmr_out), 0);
    check("R3 idle discharge", int'(discharge), 1);

    // Vector table walk: R1 R6 R7
    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][32], int'(VEC[i][31:24]), int'(VEC[i][23:16]));
      if (VEC[i][32] == 1'b0) begin
        check("R9 one-shot idle after clear", int'(tmr_out), 0);
        trig_n = 1'b0;
        @(negedge clk);
        trig_n = 1'b1;
        check("R1 discharge released", int'(discharge), 0);
        count_level(1'b1, len);
        check("R1 R7 one-shot length", len, int'(VEC[i][15:8]));
        check("R3 discharge after pulse", int'(discharge), 1);
      end else begin
        check("R9 free-run starts high", int'(tmr_out), 1);
        wait_level(1'b0);
        wait_level(1'b1);
        count_level(1'b1, len);
        count_level(1'b0, len2);
        check("R6 R7 free-run high", len, int'(VEC[i][15:8]));
        check("R6 R7 free-run low", len2, int'(VEC[i][7:0]));
      end
    end

    // R6: trigger ignored in free-running mode
    restart(1'b1, 3, 5);
    wait_level(1'b0);
    trig_n = 1'b0;
    count_level(1'b0, len);
    count_level(1'b1, len2);
    trig_n = 1'b1;
    check("R6 low with trigger held", len, 5);
    check("R6 high with trigger held", len2, 3);

    // R5: held trigger retriggers without a gap
    restart(1'b0, 4, 0);
    trig_n = 1'b0;
    len = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (tmr_out) len++;
    end
    trig_n = 1'b1;
    check("R5 high while trigger held", len, 10);
    @(negedge clk);
    count_level(1'b1, len);
    check("R5 remaining interval", len, 2);

    // R4: short trigger during high phase has no effect
    restart(1'b0, 6, 0);
    trig_n = 1'b0;
    @(negedge clk);
    trig_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    trig_n = 1'b0;
    @(negedge clk);
    trig_n = 1'b1;
    count_level(1'b1, len);
    check("R4 length with mid trigger", len + 3, 6);

    // R8: mid-phase count change applies only to later phases
    restart(1'b1, 8, 3);
    check("R8 in first high", int'(tmr_out), 1);
    high_count = CNT_W'(2);
    count_level(1'b1, len);
    count_level(1'b0, len2);
    check("R8 current phase keeps length", len, 8);
    check("R8 low phase", len2, 3);
    count_level(1'b1, len);
    check("R8 next phase uses new count", len, 2);

    // R2: clear overrides an active pulse and a held trigger
    restart(1'b0, 20, 0);
    trig_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 pulse active before clear", int'(tmr_out), 1);
    clr_n = 1'b0;
    @(negedge clk);
    check("R2 out forced low", int'(tmr_out), 0);
    check("R2 discharge forced high", int'(discharge), 1);
    len = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (tmr_out) len++;
    end
    check("R2 trigger blocked during clear", len, 0);
    trig_n = 1'b1;
    clr_n  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 idle after clear release", int'(tmr_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule